// File: doc/BRIEF.md
# Bus Request Filter

This block sits between a processor's cache miss path and a shared snooping bus. Each miss request carries a line address and one of four kinds: read (GET), read for ownership (GETX), ownership upgrade of a line already held shared (UPGRADE), and dirty-line eviction (WRITEBACK). The block decides one fate for each request. It can fail the request with a bus error, refuse it with a NAK, complete it locally with no bus traffic, or enqueue it for the bus arbiter in the high- or low-priority queue.

The block holds a small write-back buffer of evicted line addresses, each entry with its own valid bit. A read or ownership request that matches the requester's own buffer is served from that buffer. An ownership request also consumes the entry, because the cache then holds the newest copy. Two checks sit outside the block and are reached through request/reply ports: a write-protect firewall, and the tag array of the requester's cache, which reports whether an upgrading line is still shared. The block works on one request at a time. It asserts `req_ready` while it is idle.

Top module: `bus_req_filter`

## Requirements
- R1: A request whose line address is not below `ADDR_LIMIT` produces a bus error (`err_valid`), whatever its kind, and issues neither a firewall nor a tag query.
- R2: When `fw_enable` is high at acceptance, an in-range GETX (code 1) or UPGRADE (code 2) raises `fw_q_valid` with the line address, and a reply with `fw_allow` low produces a bus error. GET (code 0) and WRITEBACK (code 3) never query the firewall, and no kind queries it while `fw_enable` is low.
- R3: A GET that matches a valid write-back buffer entry completes locally (`done_valid` with `done_flags` = 2'b11, where bit 0 means the result came from memory and bit 1 means no state transition), and the entry stays valid.
- R4: A GETX or UPGRADE that matches a valid buffer entry completes locally with `done_flags` = 2'b11, and that entry is invalidated.
- R5: An in-range UPGRADE that misses the buffer raises `tag_q_valid`. If the tag reply has `tag_shared` low, the request is NAKed. No other request issues a tag query.
- R6: An in-range, firewall-independent WRITEBACK is enqueued with `enq_hi` = 0 and `rsp_type` = 3.
- R7: A GET, GETX or UPGRADE that passes every check is enqueued with `enq_hi` = 1 and `rsp_type` equal to its request code.
- R8: The checks take precedence in this order: address range, then firewall, then buffer match, then upgrade presence. The first check that fails decides the outcome.
- R9: Each accepted request produces exactly one outcome pulse, which is one cycle wide and carries `rsp_addr` equal to the request address. The pulse comes one cycle after the last required lookup reply is sampled, or one cycle after acceptance when no lookup is required. `req_ready` is low from acceptance until the pulse.
- R10: `wb_alloc_valid` writes its address into the lowest-numbered invalid buffer entry. It is ignored when every entry is valid or when the address is already held.
- R11: After reset the buffer is empty, `req_ready` is high, and no query or outcome signal is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_type | input | 2 | 0 GET, 1 GETX, 2 UPGRADE, 3 WRITEBACK |
| req_addr | input | ADDR_W | Line address |
| fw_enable | input | 1 | Firewall checking on |
| fw_q_valid | output | 1 | Firewall query pending |
| fw_q_addr | output | ADDR_W | Address under firewall query |
| fw_rsp_valid | input | 1 | Firewall reply present |
| fw_allow | input | 1 | Firewall permits the write |
| tag_q_valid | output | 1 | Tag presence query pending |
| tag_q_addr | output | ADDR_W | Address under tag query |
| tag_rsp_valid | input | 1 | Tag reply present |
| tag_shared | input | 1 | Line still held shared |
| wb_alloc_valid | input | 1 | Add an entry to the write-back buffer |
| wb_alloc_addr | input | ADDR_W | Address of the new entry |
| done_valid | output | 1 | Request completed locally |
| done_flags | output | 2 | Bit 0 memory result, bit 1 no transition |
| err_valid | output | 1 | Request fails with a bus error |
| nak_valid | output | 1 | Request refused |
| enq_valid | output | 1 | Request placed in a bus queue |
| enq_hi | output | 1 | 1 high-priority queue, 0 low-priority queue |
| rsp_type | output | 2 | Kind of the request behind the outcome |
| rsp_addr | output | ADDR_W | Address of the request behind the outcome |

## Verification
The bench builds the block with a 6-bit line address, `ADDR_LIMIT` = 48 and a four-entry buffer. With these values every address, both sides of the range limit, and every request kind can be swept exhaustively, and a completely full buffer arises constantly. Because the buffer is refilled before each request, one sweep meets many combinations: out-of-range buffer entries against the range check, firewall denials on buffered lines, and stale upgrades. Firewall and tag reply latencies vary with the address, so the outcome cycle is checked both when the firewall reply comes last and when the tag reply comes last.

// File: rtl/bus_req_filter_pkg.sv
// Shared types for the bus request filter.
// Assumes the request code values are fixed by the requester side.
package bus_req_filter_pkg;
    typedef enum logic [1:0] {
        REQ_GET  = 2'd0,
        REQ_GETX = 2'd1,
        REQ_UPG  = 2'd2,
        REQ_WB   = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        OUT_ERR,
        OUT_DONE,
        OUT_NAK,
        OUT_ENQ_HI,
        OUT_ENQ_LO
    } verdict_e;

    typedef enum logic {
        ST_IDLE,
        ST_LOOK
    } phase_e;
endpackage

// File: rtl/bus_req_wbuf.sv
// Write-back buffer tag store: DEPTH line addresses with per-entry valid bits.
// Gives a combinational match for one lookup address, takes an allocation into
// the lowest free slot (dropped when full or duplicate), and frees one slot.
// Assumes a freed slot is valid and is never the target of a same-cycle alloc.
module bus_req_wbuf #(
    parameter int AW    = 16,
    parameter int DEPTH = 8,
    parameter int IW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic [AW-1:0] alloc_addr,
    input  logic [AW-1:0] look_addr,
    output logic          look_hit,
    output logic [IW-1:0] look_idx,
    input  logic          free_valid,
    input  logic [IW-1:0] free_idx
);
    logic [AW-1:0]    tag_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] look_match;
    logic [DEPTH-1:0] alloc_match;
    logic             slot_found;
    logic [IW-1:0]    slot_idx;
    logic             alloc_ok;

    // Per-entry comparators for the lookup and the duplicate test.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign look_match[g]  = vld_q[g] && (tag_q[g] == look_addr);
        assign alloc_match[g] = vld_q[g] && (tag_q[g] == alloc_addr);
    end

    // Encode the lowest matching entry for the lookup.
    always_comb begin
        look_hit = 1'b0;
        look_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (look_match[i]) begin
                look_hit = 1'b1;
                look_idx = IW'(i);
            end
        end
    end

    // Pick the lowest invalid slot for allocation.
    always_comb begin
        slot_found = 1'b0;
        slot_idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                slot_found = 1'b1;
                slot_idx   = IW'(i);
            end
        end
    end

    assign alloc_ok = alloc_valid && slot_found && (alloc_match == '0);

    // Valid bits: set on allocation, cleared on free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (free_valid) vld_q[free_idx] <= 1'b0;
            if (alloc_ok)   vld_q[slot_idx] <= 1'b1;
        end
    end

    // Address store: written only on a successful allocation.
    always_ff @(posedge clk) begin
        if (alloc_ok) tag_q[slot_idx] <= alloc_addr;
    end

    // R4
    free_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |-> vld_q[free_idx]);

    // R10
    no_duplicate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(look_match) <= 1);
endmodule

// File: rtl/bus_req_decide.sv
// Outcome selection for one request once every needed lookup has answered.
// Applies the fixed check order: range, firewall, buffer match, upgrade presence.
// Assumes fw_ok and line_shared are ignored whenever their lookup was not needed.
module bus_req_decide
    import bus_req_filter_pkg::*;
(
    input  req_kind_e kind,
    input  logic      in_range,
    input  logic      fw_need,
    input  logic      fw_ok,
    input  logic      wb_hit,
    input  logic      line_shared,
    output verdict_e  verdict,
    output logic      free_entry
);
    // Priority chain over the checks, first failure wins.
    always_comb begin
        free_entry = 1'b0;
        if (!in_range) begin
            verdict = OUT_ERR;
        end else if (fw_need && !fw_ok) begin
            verdict = OUT_ERR;
        end else if (kind == REQ_WB) begin
            verdict = OUT_ENQ_LO;
        end else if (wb_hit) begin
            verdict    = OUT_DONE;
            free_entry = (kind != REQ_GET);
        end else if ((kind == REQ_UPG) && !line_shared) begin
            verdict = OUT_NAK;
        end else begin
            verdict = OUT_ENQ_HI;
        end
    end
endmodule

// File: rtl/bus_req_filter.sv
// Bus request filter top: accepts one miss request at a time, issues the
// firewall and tag lookups that request needs, then emits exactly one outcome
// pulse (local done, bus error, NAK or bus enqueue).
// Assumes lookup replies arrive only while the matching query is raised.
module bus_req_filter
    import bus_req_filter_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int ADDR_LIMIT = 49152,
    parameter int WB_DEPTH   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_type,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              fw_enable,
    output logic              fw_q_valid,
    output logic [ADDR_W-1:0] fw_q_addr,
    input  logic              fw_rsp_valid,
    input  logic              fw_allow,
    output logic              tag_q_valid,
    output logic [ADDR_W-1:0] tag_q_addr,
    input  logic              tag_rsp_valid,
    input  logic              tag_shared,
    input  logic              wb_alloc_valid,
    input  logic [ADDR_W-1:0] wb_alloc_addr,
    output logic              done_valid,
    output logic [1:0]        done_flags,
    output logic              err_valid,
    output logic              nak_valid,
    output logic              enq_valid,
    output logic              enq_hi,
    output logic [1:0]        rsp_type,
    output logic [ADDR_W-1:0] rsp_addr
);
    localparam int              IDX_W = (WB_DEPTH > 1) ? $clog2(WB_DEPTH) : 1;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(ADDR_LIMIT);

    phase_e            phase_q;
    req_kind_e         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic              range_q, fwneed_q, fwgot_q, fwok_q;
    logic              tagneed_q, taggot_q, tagsh_q;
    logic              hit_q;
    logic [IDX_W-1:0]  hitidx_q;

    req_kind_e         in_kind;
    logic              accept, in_range, look_hit;
    logic [IDX_W-1:0]  look_idx;
    logic              fw_ready, tag_ready, decide_now;
    logic              fw_ok_eff, tag_sh_eff, free_entry;
    verdict_e          verdict;

    assign in_kind    = req_kind_e'(req_type);
    assign req_ready  = (phase_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign in_range   = ({1'b0, req_addr} < LIMIT);
    assign fw_ready   = !fwneed_q || fwgot_q || fw_rsp_valid;
    assign tag_ready  = !tagneed_q || taggot_q || tag_rsp_valid;
    assign decide_now = (phase_q == ST_LOOK) && fw_ready && tag_ready;
    assign fw_ok_eff  = fwgot_q ? fwok_q : fw_allow;
    assign tag_sh_eff = taggot_q ? tagsh_q : tag_shared;

    assign fw_q_valid  = (phase_q == ST_LOOK) && fwneed_q && !fwgot_q;
    assign fw_q_addr   = addr_q;
    assign tag_q_valid = (phase_q == ST_LOOK) && tagneed_q && !taggot_q;
    assign tag_q_addr  = addr_q;

    bus_req_wbuf #(.AW(ADDR_W), .DEPTH(WB_DEPTH), .IW(IDX_W)) u_wbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_valid (wb_alloc_valid),
        .alloc_addr  (wb_alloc_addr),
        .look_addr   (req_addr),
        .look_hit    (look_hit),
        .look_idx    (look_idx),
        .free_valid  (decide_now && free_entry),
        .free_idx    (hitidx_q)
    );

    bus_req_decide u_decide (
        .kind        (kind_q),
        .in_range    (range_q),
        .fw_need     (fwneed_q),
        .fw_ok       (fw_ok_eff),
        .wb_hit      (hit_q),
        .line_shared (tag_sh_eff),
        .verdict     (verdict),
        .free_entry  (free_entry)
    );

    // Request capture, lookup bookkeeping and the idle/lookup phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= ST_IDLE;
            kind_q    <= REQ_GET;
            addr_q    <= '0;
            range_q   <= 1'b0;
            fwneed_q  <= 1'b0;
            fwgot_q   <= 1'b0;
            fwok_q    <= 1'b0;
            tagneed_q <= 1'b0;
            taggot_q  <= 1'b0;
            tagsh_q   <= 1'b0;
            hit_q     <= 1'b0;
            hitidx_q  <= '0;
        end else if (accept) begin
            phase_q   <= ST_LOOK;
            kind_q    <= in_kind;
            addr_q    <= req_addr;
            range_q   <= in_range;
            fwneed_q  <= in_range && fw_enable &&
                         ((in_kind == REQ_GETX) || (in_kind == REQ_UPG));
            fwgot_q   <= 1'b0;
            tagneed_q <= in_range && (in_kind == REQ_UPG) && !look_hit;
            taggot_q  <= 1'b0;
            hit_q     <= look_hit;
            hitidx_q  <= look_idx;
        end else if (decide_now) begin
            phase_q <= ST_IDLE;
        end else begin
            if (fw_q_valid && fw_rsp_valid) begin
                fwgot_q <= 1'b1;
                fwok_q  <= fw_allow;
            end
            if (tag_q_valid && tag_rsp_valid) begin
                taggot_q <= 1'b1;
                tagsh_q  <= tag_shared;
            end
        end
    end

    // Registered one-cycle outcome pulse and its descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid <= 1'b0;
            done_flags <= 2'b00;
            err_valid  <= 1'b0;
            nak_valid  <= 1'b0;
            enq_valid  <= 1'b0;
            enq_hi     <= 1'b0;
            rsp_type   <= 2'd0;
            rsp_addr   <= '0;
        end else begin
            done_valid <= decide_now && (verdict == OUT_DONE);
            err_valid  <= decide_now && (verdict == OUT_ERR);
            nak_valid  <= decide_now && (verdict == OUT_NAK);
            enq_valid  <= decide_now &&
                          ((verdict == OUT_ENQ_HI) || (verdict == OUT_ENQ_LO));
            if (decide_now) begin
                done_flags <= (verdict == OUT_DONE) ? 2'b11 : 2'b00;
                enq_hi     <= (verdict == OUT_ENQ_HI);
                rsp_type   <= kind_q;
                rsp_addr   <= addr_q;
            end
        end
    end

    // R9
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_valid, err_valid, nak_valid, enq_valid}));

    // R9
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid || err_valid || nak_valid || enq_valid) |=>
        !(done_valid || err_valid || nak_valid || enq_valid));

    // R9
    busy_during_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_q_valid || tag_q_valid) |-> !req_ready);

    // R1
    query_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_q_valid || tag_q_valid) |-> ({1'b0, fw_q_addr} < LIMIT));

    // R2
    fw_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fw_q_valid |-> ((kind_q == REQ_GETX) || (kind_q == REQ_UPG)));

    // R5
    tag_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_q_valid |-> (kind_q == REQ_UPG));
endmodule

// File: tb/bus_req_filter_tb.sv
module bus_req_filter_tb;
    localparam int AW    = 6;
    localparam int LIM   = 48;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_type = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic          fw_enable = 1'b0;
    logic          fw_q_valid;
    logic [AW-1:0] fw_q_addr;
    logic          fw_rsp_valid = 1'b0;
    logic          fw_allow = 1'b0;
    logic          tag_q_valid;
    logic [AW-1:0] tag_q_addr;
    logic          tag_rsp_valid = 1'b0;
    logic          tag_shared = 1'b0;
    logic          wb_alloc_valid = 1'b0;
    logic [AW-1:0] wb_alloc_addr = '0;
    logic          done_valid;
    logic [1:0]    done_flags;
    logic          err_valid, nak_valid, enq_valid, enq_hi;
    logic [1:0]    rsp_type;
    logic [AW-1:0] rsp_addr;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Bench model of the buffer, kept from R10's placement rule.
    int m_addr [DEPTH];
    bit m_vld  [DEPTH];

    always #10 clk = ~clk;

    bus_req_filter #(.ADDR_W(AW), .ADDR_LIMIT(LIM), .WB_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type), .req_addr(req_addr),
        .fw_enable(fw_enable), .fw_q_valid(fw_q_valid), .fw_q_addr(fw_q_addr),
        .fw_rsp_valid(fw_rsp_valid), .fw_allow(fw_allow),
        .tag_q_valid(tag_q_valid), .tag_q_addr(tag_q_addr),
        .tag_rsp_valid(tag_rsp_valid), .tag_shared(tag_shared),
        .wb_alloc_valid(wb_alloc_valid), .wb_alloc_addr(wb_alloc_addr),
        .done_valid(done_valid), .done_flags(done_flags), .err_valid(err_valid),
        .nak_valid(nak_valid), .enq_valid(enq_valid), .enq_hi(enq_hi),
        .rsp_type(rsp_type), .rsp_addr(rsp_addr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic alloc(input int a);
        bit present = 0;
        bit placed = 0;
        @(negedge clk);
        wb_alloc_valid = 1'b1;
        wb_alloc_addr  = AW'(a);
        for (int i = 0; i < DEPTH; i++) if (m_vld[i] && m_addr[i] == a) present = 1;
        if (!present) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!m_vld[i] && !placed) begin
                    m_vld[i] = 1; m_addr[i] = a; placed = 1;
                end
            end
        end
        @(negedge clk);
        wb_alloc_valid = 1'b0;
    endtask

    // Outcome kinds: 0 error, 1 done, 2 nak, 3 high enqueue, 4 low enqueue.
    task automatic run_req(input int t, input int a, input bit fwen, input bit allow,
                           input bit shared, input int fl, input int tl, input string tag);
        bit in_r, fwneed, tagneed, hit, got, fwseen, tagseen, fwdone, tagdone;
        int hidx, ek, ecyc, ak, acyc, aflags, atype, aaddr, n;
        string rq;
        in_r = (a < LIM);
        fwneed = in_r && fwen && (t == 1 || t == 2);
        hit = 0; hidx = 0;
        for (int i = DEPTH - 1; i >= 0; i--) if (m_vld[i] && m_addr[i] == a) begin hit = 1; hidx = i; end
        tagneed = in_r && (t == 2) && !hit;
        if (!in_r) begin ek = 0; rq = "R1"; end
        else if (fwneed && !allow) begin ek = 0; rq = "R2"; end
        else if (t == 3) begin ek = 4; rq = "R6"; end
        else if (hit) begin ek = 1; rq = (t == 0) ? "R3" : "R4"; end
        else if (t == 2 && !shared) begin ek = 2; rq = "R5"; end
        else begin ek = 3; rq = "R7"; end
        if (ek == 1 && t != 0) m_vld[hidx] = 0;
        ecyc = 1;
        if (fwneed) ecyc = fl + 1;
        if (tagneed && tl + 1 > ecyc) ecyc = tl + 1;

        @(negedge clk);
        chk(req_ready == 1'b1, {"R9 ready idle ", tag}, req_ready, 1);
        req_valid = 1'b1; req_type = 2'(t); req_addr = AW'(a); fw_enable = fwen;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {"R9 busy ", tag}, req_ready, 0);
        got = 0; fwseen = 0; tagseen = 0; fwdone = 0; tagdone = 0;
        ak = -1; acyc = -1; aflags = 0; atype = 0; aaddr = 0;
        for (int c = 0; c < 40 && !got; c++) begin
            if (c > 0) @(negedge clk);
            n = int'(done_valid) + int'(err_valid) + int'(nak_valid) + int'(enq_valid);
            if (n > 0) begin
                got = 1; acyc = c;
                chk(n == 1, {"R9 single outcome ", tag}, n, 1);
                if (err_valid) ak = 0;
                else if (done_valid) ak = 1;
                else if (nak_valid) ak = 2;
                else ak = enq_hi ? 3 : 4;
                aflags = int'(done_flags); atype = int'(rsp_type); aaddr = int'(rsp_addr);
            end
            if (fw_q_valid) begin
                fwseen = 1;
                chk(int'(fw_q_addr) == a, {"R2 query addr ", tag}, int'(fw_q_addr), a);
            end
            if (tag_q_valid) tagseen = 1;
            fw_rsp_valid = 1'b0; tag_rsp_valid = 1'b0;
            if (fw_q_valid && !fwdone && c >= fl) begin
                fw_rsp_valid = 1'b1; fw_allow = allow; fwdone = 1;
            end
            if (tag_q_valid && !tagdone && c >= tl) begin
                tag_rsp_valid = 1'b1; tag_shared = shared; tagdone = 1;
            end
        end
        fw_rsp_valid = 1'b0; tag_rsp_valid = 1'b0;
        // R8: precedence decides which of the kinds is expected
        chk(ak == ek, {"R8/", rq, " outcome ", tag}, ak, ek);
        chk(acyc == ecyc, {"R9 cycle ", tag}, acyc, ecyc);
        chk(aaddr == a, {"R9 addr ", tag}, aaddr, a);
        chk(fwseen == fwneed, {"R2 fw query ", tag}, fwseen, fwneed);
        chk(tagseen == tagneed, {"R5 tag query ", tag}, tagseen, tagneed);
        if (ek == 1) chk(aflags == 3, {rq, " flags ", tag}, aflags, 3);
        if (ek >= 3) chk(atype == t, {rq, " type ", tag}, atype, t);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        // R11 reset state
        chk(req_ready == 1'b1, "R11 ready", req_ready, 1);
        chk({done_valid, err_valid, nak_valid, enq_valid} == 4'b0, "R11 outcomes",
            {done_valid, err_valid, nak_valid, enq_valid}, 0);
        chk({fw_q_valid, tag_q_valid} == 2'b0, "R11 queries", {fw_q_valid, tag_q_valid}, 0);

        // Sweep 1: empty buffer, firewall off, every kind and address.
        for (int t = 0; t < 4; t++)
            for (int a = 0; a < 64; a++)
                run_req(t, a, 1'b0, 1'b1, a[0], 0, a % 3, "sweep1");

        // Sweep 2: buffer refilled each time, firewall on, varied latencies.
        for (int t = 0; t < 4; t++)
            for (int a = 0; a < 64; a++) begin
                alloc(5); alloc(9); alloc(47); alloc(50);
                run_req(t, a, 1'b1, (a % 3) != 0, a[2], a % 4, (a >> 2) % 3, "sweep2");
            end

        // R10 placement, full-buffer and duplicate handling.
        do_reset();
        alloc(10); alloc(20); alloc(30); alloc(40);
        alloc(11);
        run_req(0, 11, 1'b0, 1'b1, 1'b0, 0, 0, "R10 full drop");
        run_req(1, 10, 1'b0, 1'b1, 1'b0, 0, 0, "R10 free slot0");
        alloc(20);
        alloc(11);
        run_req(0, 11, 1'b0, 1'b1, 1'b0, 0, 0, "R10 refill");
        run_req(0, 11, 1'b0, 1'b1, 1'b0, 0, 0, "R3 kept");
        run_req(2, 20, 1'b0, 1'b1, 1'b0, 0, 0, "R10 dup free");
        run_req(0, 20, 1'b0, 1'b1, 1'b0, 0, 0, "R10 dup gone");

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule